// File: doc/BRIEF.md
# Paged Shared-Memory Address Translator

This block sits between a network controller, a host bus and a shared board RAM. Both the controller and the host issue 24-bit addresses. A writable table of 1024 page slots turns each address into a physical word address in RAM. Because both sides go through the same table, they always see the same memory image.

Each table entry names a 1 KB physical frame, a byte order for the page and a RAM bank for the page. The byte order is either the host's big-endian order or the controller's little-endian order. The bank is either on-board memory or memory on an auxiliary expansion bus. No entry can fault: the table has no valid or protection bits, so every address translates.

The controller has priority over the host. The host waits on a ready handshake. Software reaches the table through a small register port. After reset, a clearing sweep zeroes every entry before any traffic is accepted. A common setup points the top slot at the same frame as slot 0. The controller's startup pointer, which lives near the top of its address space, then lands in ordinary low memory.

Top module: `pgmap_xlate`

## Requirements
- R1: Address bits [23:20] are ignored. Bits [19:10] pick the table slot and bits [9:1] pick the 16-bit word in the page. `ram_addr` is {entry[11:0], address[9:1]}.
- R2: Every accepted request produces exactly one RAM access, with `ram_req` high in the second cycle after acceptance. There is no fault path.
- R3: Entry bit 15 clear selects little-endian order. The two bytes of every data word are then swapped on the way to RAM and on the way back, and `ram_swap` is 1. Bit 15 set passes data unchanged, and `ram_swap` is 0.
- R4: Entry bit 13 is driven on `ram_aux` (1 = auxiliary bus memory, 0 = on-board memory).
- R5: A 16-bit access has `ram_be` = 2'b11. An 8-bit access uses address bit 0 as the requester's lane (0 = bits [7:0], 1 = bits [15:8]) and enables one RAM lane. Under little-endian order the RAM lane is the opposite one. Byte reads return the whole word.
- R6: When both sides request in one cycle, the controller is served and `hst_ready` stays low. The host request is taken in the first cycle with `hst_ready` high. `ctl_ready` is high whenever the sweep is finished.
- R7: Controller and host accesses are translated by the same table.
- R8: On reset every entry clears to 0 during a sweep of 1024 cycles. During the sweep both ready outputs are low, no RAM access is issued, and table-port writes and reads are ignored.
- R9: A table write in cycle t applies to requests accepted from cycle t+1 on. A request accepted in cycle t still uses the old entry.
- R10: A table read returns the entry on `map_rdata`, with `map_rvalid` high, in the cycle after the read.
- R11: RAM read data is expected one cycle after `ram_req`. It is returned, with byte order restored, on the requester's own read-data output in the following cycle, with that side's valid high.
- R12: Slot 1023 may name the same frame as slot 0. Addresses 0xFFFC00 to 0xFFFFFF, including the startup pointer at page offset 0x3F4, then reach the same words as 0x000000 to 0x0003FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_wr_en | input | 1 | Table write strobe |
| map_rd_en | input | 1 | Table read strobe |
| map_idx | input | 10 | Table slot for read or write |
| map_wdata | input | 16 | Entry to write |
| map_rdata | output | 16 | Entry read back |
| map_rvalid | output | 1 | `map_rdata` valid |
| ctl_req | input | 1 | Controller request |
| ctl_ready | output | 1 | Controller request accepted this cycle |
| ctl_we | input | 1 | Controller write (1) or read (0) |
| ctl_byte | input | 1 | Controller 8-bit access |
| ctl_addr | input | 24 | Controller address |
| ctl_wdata | input | 16 | Controller write data |
| ctl_rdata | output | 16 | Controller read data |
| ctl_rvalid | output | 1 | `ctl_rdata` valid |
| hst_req | input | 1 | Host request, held until accepted |
| hst_ready | output | 1 | Host request accepted this cycle |
| hst_we | input | 1 | Host write (1) or read (0) |
| hst_byte | input | 1 | Host 8-bit access |
| hst_addr | input | 24 | Host address |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data |
| hst_rvalid | output | 1 | `hst_rdata` valid |
| ram_req | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write |
| ram_addr | output | 21 | Physical word address {frame, word} |
| ram_be | output | 2 | RAM byte-lane enables |
| ram_wdata | output | 16 | RAM write data, already in RAM byte order |
| ram_aux | output | 1 | Bank select: 1 auxiliary bus, 0 on-board |
| ram_swap | output | 1 | The page of this access is stored byte-swapped |
| ram_rdata | input | 16 | RAM read data, one cycle after `ram_req` |

## Verification
Some properties are checked on every cycle:
- each accepted request leads to a RAM access two cycles later;
- the controller's slot comes first in a shared cycle;
- read data returns to one requester only, two cycles after a RAM read;
- RAM stays quiet during the clearing sweep;
- the sweep does not end early.

Other behaviours can only be shown by the bench's scenarios, because they depend on table contents and on RAM holding data:
- byte swapping across both byte orders;
- lane inversion for byte writes;
- bank separation;
- aliasing of the top slot;
- the cycle in which a table write takes effect.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  // Which side a translated access belongs to.
  typedef enum logic {
    SRC_CTL = 1'b0,
    SRC_HST = 1'b1
  } src_e;
endpackage

// File: rtl/pmx_map_ram.sv
// Page table storage: one write/read port for the register side and the
// reset sweep, one read-only port for translation. Both reads are registered
// so the array maps onto a simple dual-port block RAM.
module pmx_map_ram #(
  parameter int SLOT_W = 10,
  parameter int ENT_W  = 16,
  localparam int DEPTH = 1 << SLOT_W
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic [SLOT_W-1:0] a_addr,
  input  logic [ENT_W-1:0]  a_wdata,
  output logic [ENT_W-1:0]  a_rdata,
  input  logic [SLOT_W-1:0] b_addr,
  output logic [ENT_W-1:0]  b_rdata
);
  logic [ENT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    else      a_rdata     <= mem[a_addr];
  end

  // A same-cycle write on port A is not seen here (old entry returned).
  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/pmx_init_arb.sv
// Clearing sweep after reset plus fixed-priority choice between the two
// requesters (controller first).
module pmx_init_arb #(
  parameter int SLOT_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_req,
  input  logic              hst_req,
  output logic              init_busy,
  output logic [SLOT_W-1:0] init_idx,
  output logic              ctl_ready,
  output logic              hst_ready,
  output logic              take,
  output logic              take_hst
);
  always_ff @(posedge clk) begin
    if (rst) begin
      init_busy <= 1'b1;
      init_idx  <= '0;
    end else if (init_busy) begin
      init_idx <= init_idx + 1'b1;
      if (init_idx == {SLOT_W{1'b1}}) init_busy <= 1'b0;
    end
  end

  always_comb begin
    ctl_ready = !init_busy;
    hst_ready = !init_busy && !ctl_req;
    take      = (ctl_req && ctl_ready) || (hst_req && hst_ready);
    take_hst  = !ctl_req;
  end

  AST_SWEEP_FULL: assert property (@(posedge clk) disable iff (rst)
    (init_busy && init_idx != {SLOT_W{1'b1}}) |=> init_busy); // R8
endmodule

// File: rtl/pmx_bswap.sv
// Conditional byte-order reversal of one data word.
module pmx_bswap #(
  parameter int DW = 16,
  localparam int NB = DW / 8
) (
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] rev;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign rev[i*8 +: 8] = din[(NB-1-i)*8 +: 8];
  end

  assign dout = en ? rev : din;
endmodule

// File: rtl/pmx_lane.sv
// Write-side lane steering: swaps the word for little-endian pages and
// turns the requester's byte lane into a RAM byte enable.
module pmx_lane #(
  parameter int DW = 16,
  localparam int NB = DW / 8,
  localparam int LW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          swap,
  input  logic          byt,
  input  logic [LW-1:0] lane,
  input  logic [DW-1:0] wd_in,
  output logic [DW-1:0] wd_out,
  output logic [NB-1:0] be
);
  logic [LW-1:0] plane;

  pmx_bswap #(.DW(DW)) u_wswap (
    .en   (swap),
    .din  (wd_in),
    .dout (wd_out)
  );

  always_comb begin
    plane = swap ? (LW'(NB - 1) - lane) : lane;
    be    = byt ? (NB'(1) << plane) : {NB{1'b1}};
  end
endmodule

// File: rtl/pgmap_xlate.sv
module pgmap_xlate
  import pmx_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int SLOT_W  = 10,
  parameter int OFF_W   = 10,
  parameter int PFN_W   = 12,
  parameter int DW      = 16,
  parameter int ENT_W   = 16,
  parameter int BE_BIT  = 15,
  parameter int AUX_BIT = 13,
  localparam int NB     = DW / 8,
  localparam int LW     = (NB > 1) ? $clog2(NB) : 1,
  localparam int WORD_W = OFF_W - LW,
  localparam int RA_W   = PFN_W + WORD_W,
  localparam int IGN_W  = ADDR_W - SLOT_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              map_wr_en,
  input  logic              map_rd_en,
  input  logic [SLOT_W-1:0] map_idx,
  input  logic [ENT_W-1:0]  map_wdata,
  output logic [ENT_W-1:0]  map_rdata,
  output logic              map_rvalid,
  input  logic              ctl_req,
  output logic              ctl_ready,
  input  logic              ctl_we,
  input  logic              ctl_byte,
  input  logic [ADDR_W-1:0] ctl_addr,
  input  logic [DW-1:0]     ctl_wdata,
  output logic [DW-1:0]     ctl_rdata,
  output logic              ctl_rvalid,
  input  logic              hst_req,
  output logic              hst_ready,
  input  logic              hst_we,
  input  logic              hst_byte,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [DW-1:0]     hst_wdata,
  output logic [DW-1:0]     hst_rdata,
  output logic              hst_rvalid,
  output logic              ram_req,
  output logic              ram_we,
  output logic [RA_W-1:0]   ram_addr,
  output logic [NB-1:0]     ram_be,
  output logic [DW-1:0]     ram_wdata,
  output logic              ram_aux,
  output logic              ram_swap,
  input  logic [DW-1:0]     ram_rdata
);
  // ---------------- arbitration and reset sweep ----------------
  logic              init_busy;
  logic [SLOT_W-1:0] init_idx;
  logic              take, take_hst;

  pmx_init_arb #(.SLOT_W(SLOT_W)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .ctl_req   (ctl_req),
    .hst_req   (hst_req),
    .init_busy (init_busy),
    .init_idx  (init_idx),
    .ctl_ready (ctl_ready),
    .hst_ready (hst_ready),
    .take      (take),
    .take_hst  (take_hst)
  );

  // ---------------- table storage ----------------
  logic              a_we;
  logic [SLOT_W-1:0] a_addr;
  logic [ENT_W-1:0]  a_wdata;
  logic [ENT_W-1:0]  entry;
  logic [ADDR_W-1:0] sel_addr;
  logic [SLOT_W-1:0] b_addr;

  always_comb begin
    a_we     = init_busy || map_wr_en;
    a_addr   = init_busy ? init_idx : map_idx;
    a_wdata  = init_busy ? '0 : map_wdata;
    sel_addr = take_hst ? hst_addr : ctl_addr;
    b_addr   = sel_addr[OFF_W +: SLOT_W];
  end

  pmx_map_ram #(.SLOT_W(SLOT_W), .ENT_W(ENT_W)) u_map (
    .clk     (clk),
    .a_we    (a_we),
    .a_addr  (a_addr),
    .a_wdata (a_wdata),
    .a_rdata (map_rdata),
    .b_addr  (b_addr),
    .b_rdata (entry)
  );

  always_ff @(posedge clk) begin
    if (rst) map_rvalid <= 1'b0;
    else     map_rvalid <= !init_busy && map_rd_en && !map_wr_en;
  end

  // ---------------- stage 1: request held while the entry is read ----------------
  logic              s1_v, s1_we, s1_byt;
  src_e              s1_src;
  logic [LW-1:0]     s1_lane;
  logic [WORD_W-1:0] s1_word;
  logic [DW-1:0]     s1_wd;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
    end else begin
      s1_v <= take;
    end
    s1_src  <= take_hst ? SRC_HST : SRC_CTL;
    s1_we   <= take_hst ? hst_we : ctl_we;
    s1_byt  <= take_hst ? hst_byte : ctl_byte;
    s1_wd   <= take_hst ? hst_wdata : ctl_wdata;
    s1_lane <= sel_addr[LW-1:0];
    s1_word <= sel_addr[OFF_W-1:LW];
  end

  // ---------------- stage 2: registered RAM request ----------------
  logic          s1_swap;
  logic [DW-1:0] lane_wd;
  logic [NB-1:0] lane_be;
  src_e          s2_src;

  assign s1_swap = !entry[BE_BIT];

  pmx_lane #(.DW(DW)) u_wlane (
    .swap   (s1_swap),
    .byt    (s1_byt),
    .lane   (s1_lane),
    .wd_in  (s1_wd),
    .wd_out (lane_wd),
    .be     (lane_be)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_req <= 1'b0;
      ram_we  <= 1'b0;
    end else begin
      ram_req <= s1_v;
      ram_we  <= s1_v && s1_we;
    end
    ram_addr  <= {entry[PFN_W-1:0], s1_word};
    ram_be    <= lane_be;
    ram_wdata <= lane_wd;
    ram_aux   <= entry[AUX_BIT];
    ram_swap  <= s1_swap;
    s2_src    <= s1_src;
  end

  // ---------------- stage 3: read return ----------------
  logic          rp_v, rp_swap;
  src_e          rp_src;
  logic [DW-1:0] rd_fix;

  always_ff @(posedge clk) begin
    if (rst) rp_v <= 1'b0;
    else     rp_v <= ram_req && !ram_we;
    rp_src  <= s2_src;
    rp_swap <= ram_swap;
  end

  pmx_bswap #(.DW(DW)) u_rswap (
    .en   (rp_swap),
    .din  (ram_rdata),
    .dout (rd_fix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_rvalid <= 1'b0;
      hst_rvalid <= 1'b0;
      ctl_rdata  <= '0;
      hst_rdata  <= '0;
    end else begin
      ctl_rvalid <= rp_v && (rp_src == SRC_CTL);
      hst_rvalid <= rp_v && (rp_src == SRC_HST);
      if (rp_v && rp_src == SRC_CTL) ctl_rdata <= rd_fix;
      if (rp_v && rp_src == SRC_HST) hst_rdata <= rd_fix;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{ctl_addr[ADDR_W-1 -: IGN_W], hst_addr[ADDR_W-1 -: IGN_W], entry};

  // ---------------- assertions ----------------
  AST_ACCEPT_TO_RAM: assert property (@(posedge clk) disable iff (rst)
    take |-> ##2 ram_req); // R2

  AST_CTL_FIRST: assert property (@(posedge clk) disable iff (rst)
    (ctl_req && ctl_ready && hst_req) |-> ##2 (ram_req && s2_src == SRC_CTL)); // R6

  AST_RD_RETURN: assert property (@(posedge clk) disable iff (rst)
    (ctl_rvalid || hst_rvalid) |-> $past(ram_req && !ram_we, 2)); // R11

  AST_RV_ONE_SIDE: assert property (@(posedge clk) disable iff (rst)
    !(ctl_rvalid && hst_rvalid)); // R11

  AST_QUIET_SWEEP: assert property (@(posedge clk) disable iff (rst)
    init_busy |-> !ram_req); // R8

  AST_MAP_READ: assert property (@(posedge clk) disable iff (rst)
    (map_rd_en && !map_wr_en && !init_busy) |=> map_rvalid); // R10
endmodule

// File: tb/pgmap_xlate_tb.sv
`timescale 1ns/100ps
module pgmap_xlate_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst;
  logic        map_wr_en, map_rd_en;
  logic [9:0]  map_idx;
  logic [15:0] map_wdata, map_rdata;
  logic        map_rvalid;
  logic        ctl_req, ctl_ready, ctl_we, ctl_byte, ctl_rvalid;
  logic [23:0] ctl_addr;
  logic [15:0] ctl_wdata, ctl_rdata;
  logic        hst_req, hst_ready, hst_we, hst_byte, hst_rvalid;
  logic [23:0] hst_addr;
  logic [15:0] hst_wdata, hst_rdata;
  logic        ram_req, ram_we, ram_aux, ram_swap;
  logic [20:0] ram_addr;
  logic [1:0]  ram_be;
  logic [15:0] ram_wdata, ram_rdata;

  int total = 0;
  int bad   = 0;

  pgmap_xlate u_dut (
    .clk(clk), .rst(rst),
    .map_wr_en(map_wr_en), .map_rd_en(map_rd_en), .map_idx(map_idx),
    .map_wdata(map_wdata), .map_rdata(map_rdata), .map_rvalid(map_rvalid),
    .ctl_req(ctl_req), .ctl_ready(ctl_ready), .ctl_we(ctl_we), .ctl_byte(ctl_byte),
    .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .ctl_rvalid(ctl_rvalid),
    .hst_req(hst_req), .hst_ready(hst_ready), .hst_we(hst_we), .hst_byte(hst_byte),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_rvalid(hst_rvalid),
    .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr), .ram_be(ram_be),
    .ram_wdata(ram_wdata), .ram_aux(ram_aux), .ram_swap(ram_swap), .ram_rdata(ram_rdata)
  );

  // RAM model: bank bit, low 3 frame bits, 9 word bits; read data one cycle later.
  logic [15:0] mem [8192];
  logic [12:0] midx;
  assign midx = {ram_aux, ram_addr[11:0]};
  initial for (int k = 0; k < 8192; k++) mem[k] = 16'h0000;
  always @(posedge clk) begin
    if (ram_req) begin
      if (ram_we) begin
        if (ram_be[0]) mem[midx][7:0]  <= ram_wdata[7:0];
        if (ram_be[1]) mem[midx][15:8] <= ram_wdata[15:8];
      end else begin
        ram_rdata <= mem[midx];
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic map_write(input logic [9:0] idx, input logic [15:0] d);
    @(negedge clk);
    map_wr_en = 1'b1; map_idx = idx; map_wdata = d;
    @(negedge clk);
    map_wr_en = 1'b0;
  endtask

  task automatic map_read(input logic [9:0] idx, input logic [15:0] exp, input string req);
    @(negedge clk);
    map_rd_en = 1'b1; map_idx = idx;
    @(negedge clk);
    map_rd_en = 1'b0;
    chk(req, "map_rvalid", 32'(map_rvalid), 32'd1);
    chk(req, "map_rdata", 32'(map_rdata), 32'(exp));
  endtask

  typedef struct packed {
    logic        hst;
    logic        we;
    logic        byt;
    logic [23:0] addr;
    logic [15:0] wd;
    logic [15:0] rd;
    logic [20:0] ra;
    logic [1:0]  be;
    logic        aux;
    logic        sw;
  } vec_t;

  // Table used: slot0=8000 slot1=0001 slot2=A002 slot3=8001 slot4=8002 slot1023=8000
  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 1'b0, 24'h000010, 16'h1234, 16'h0000, 21'h000008, 2'b11, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b0, 24'hF00010, 16'h0000, 16'h1234, 21'h000008, 2'b11, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b0, 24'h000404, 16'hABCD, 16'h0000, 21'h000202, 2'b11, 1'b0, 1'b1},
    '{1'b0, 1'b0, 1'b0, 24'h000404, 16'h0000, 16'hABCD, 21'h000202, 2'b11, 1'b0, 1'b1},
    '{1'b1, 1'b0, 1'b0, 24'h000C04, 16'h0000, 16'hCDAB, 21'h000202, 2'b11, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b1, 24'h000C07, 16'h5A00, 16'h0000, 21'h000203, 2'b10, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b1, 24'h000407, 16'h7700, 16'h0000, 21'h000203, 2'b01, 1'b0, 1'b1},
    '{1'b1, 1'b0, 1'b0, 24'h000C06, 16'h0000, 16'h5A77, 21'h000203, 2'b11, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b0, 24'h000406, 16'h0000, 16'h775A, 21'h000203, 2'b11, 1'b0, 1'b1},
    '{1'b0, 1'b1, 1'b0, 24'h000800, 16'h0F0F, 16'h0000, 21'h000400, 2'b11, 1'b1, 1'b0},
    '{1'b1, 1'b0, 1'b0, 24'h001000, 16'h0000, 16'h0000, 21'h000400, 2'b11, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b0, 24'h000800, 16'h0000, 16'h0F0F, 21'h000400, 2'b11, 1'b1, 1'b0},
    '{1'b0, 1'b0, 1'b0, 24'hFFFC10, 16'h0000, 16'h1234, 21'h000008, 2'b11, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b0, 24'hFFFFF4, 16'h00C0, 16'h0000, 21'h0001FA, 2'b11, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b0, 24'h0003F4, 16'h0000, 16'h00C0, 21'h0001FA, 2'b11, 1'b0, 1'b0}
  };
  localparam string TAGS [NV] = '{"R1", "R7", "R3", "R3", "R7", "R5", "R5", "R5",
                                  "R3", "R4", "R4", "R4", "R12", "R12", "R12"};

  task automatic run_vec(input vec_t v, input string tag);
    @(negedge clk);
    if (v.hst) begin
      hst_req = 1'b1; hst_we = v.we; hst_byte = v.byt; hst_addr = v.addr; hst_wdata = v.wd;
    end else begin
      ctl_req = 1'b1; ctl_we = v.we; ctl_byte = v.byt; ctl_addr = v.addr; ctl_wdata = v.wd;
    end
    #1;
    while (!(v.hst ? hst_ready : ctl_ready)) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
    @(negedge clk);
    hst_req = 1'b0; ctl_req = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R2", "ram_req", 32'(ram_req), 32'd1);
    chk("R2", "ram_we", 32'(ram_we), 32'(v.we));
    chk("R1", "ram_addr", 32'(ram_addr), 32'(v.ra));
    chk("R5", "ram_be", 32'(ram_be), 32'(v.be));
    chk("R4", "ram_aux", 32'(ram_aux), 32'(v.aux));
    chk("R3", "ram_swap", 32'(ram_swap), 32'(v.sw));
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    if (!v.we) begin
      chk("R11", "rvalid", 32'(v.hst ? hst_rvalid : ctl_rvalid), 32'd1);
      chk(tag, "rdata", 32'(v.hst ? hst_rdata : ctl_rdata), 32'(v.rd));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    rst = 1'b1;
    map_wr_en = 1'b0; map_rd_en = 1'b0; map_idx = '0; map_wdata = '0;
    ctl_req = 1'b0; ctl_we = 1'b0; ctl_byte = 1'b0; ctl_addr = '0; ctl_wdata = '0;
    hst_req = 1'b0; hst_we = 1'b0; hst_byte = 1'b0; hst_addr = '0; hst_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    chk("R8", "ctl_ready in reset", 32'(ctl_ready), 32'd0);
    chk("R8", "hst_ready in reset", 32'(hst_ready), 32'd0);
    chk("R8", "ram_req in reset", 32'(ram_req), 32'd0);
    chk("R10", "map_rvalid in reset", 32'(map_rvalid), 32'd0);
    chk("R11", "rvalid in reset", 32'(ctl_rvalid | hst_rvalid), 32'd0);
    rst = 1'b0;
    // R8: a table write during the sweep is ignored
    map_wr_en = 1'b1; map_idx = 10'd7; map_wdata = 16'h1234;
    n = 0;
    @(negedge clk); n++;
    map_wr_en = 1'b0;
    chk("R8", "hst_ready during sweep", 32'(hst_ready), 32'd0);
    while (!ctl_ready) begin
      @(negedge clk); n++;
    end
    chk("R8", "sweep length", 32'(n), 32'd1024);
    map_read(10'd7, 16'h0000, "R8");
    map_read(10'd9, 16'h0000, "R8");

    map_write(10'd0, 16'h8000);
    map_write(10'd1, 16'h0001);
    map_write(10'd2, 16'hA002);
    map_write(10'd3, 16'h8001);
    map_write(10'd4, 16'h8002);
    map_write(10'd1023, 16'h8000);
    map_read(10'd3, 16'h8001, "R10");
    map_read(10'd2, 16'hA002, "R10");

    for (int i = 0; i < NV; i++) run_vec(VEC[i], TAGS[i]);

    // R6: simultaneous requests, controller served first
    @(negedge clk);
    ctl_req = 1'b1; ctl_we = 1'b0; ctl_byte = 1'b0; ctl_addr = 24'h000800;
    hst_req = 1'b1; hst_we = 1'b0; hst_byte = 1'b0; hst_addr = 24'h000010;
    #1;
    chk("R6", "hst_ready on clash", 32'(hst_ready), 32'd0);
    chk("R6", "ctl_ready on clash", 32'(ctl_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    ctl_req = 1'b0;
    #1;
    chk("R6", "hst_ready after clash", 32'(hst_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    hst_req = 1'b0;
    chk("R6", "first access is controller", 32'({ram_req, ram_aux}), 32'd3);
    @(posedge clk);
    @(negedge clk);
    chk("R6", "second access is host", 32'({ram_req, ram_aux}), 32'd2);
    @(posedge clk);
    @(negedge clk);
    chk("R11", "ctl_rvalid", 32'(ctl_rvalid), 32'd1);
    chk("R11", "ctl_rdata", 32'(ctl_rdata), 32'h0F0F);
    chk("R11", "no host data yet", 32'(hst_rvalid), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R11", "hst_rvalid", 32'(hst_rvalid), 32'd1);
    chk("R11", "hst_rdata", 32'(hst_rdata), 32'h1234);

    // R9: table write and request in the same cycle, then a request in the next
    @(negedge clk);
    map_wr_en = 1'b1; map_idx = 10'd6; map_wdata = 16'h8001;
    ctl_req = 1'b1; ctl_we = 1'b0; ctl_byte = 1'b0; ctl_addr = 24'h001810;
    @(posedge clk);
    @(negedge clk);
    map_wr_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    ctl_req = 1'b0;
    chk("R9", "same-cycle uses old frame", 32'(ram_addr), 32'h000008);
    chk("R9", "same-cycle uses old order", 32'(ram_swap), 32'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R9", "next-cycle uses new frame", 32'(ram_addr), 32'h000208);
    chk("R9", "next-cycle uses new order", 32'(ram_swap), 32'd0);
    repeat (4) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule